// File: doc/BRIEF.md
# Standby Detect and Auxiliary Bias Enable Controller

This block decides when the bias switch feeding a downstream auxiliary converter (typically a power-factor stage) is closed. It watches synchronous comparator results taken from the feedback path of a current-mode converter. When the feedback level falls below the light-load level (a quarter of the maximum peak setting), it asks the pulse generator to skip cycles at once. It then starts a confirmation timer. The bias switch opens only if the light-load condition lasts for the whole confirmation window.

Leaving standby is asymmetric. It uses a separate, higher comparator (the exit threshold, about 1.25 V against the 0.75 V light-load level) and acts with no delay. Ripple on the feedback around the light-load level during standby therefore cannot bring the switch back. The switch is also held open during startup and whenever a confirmed fault or an external latch-off is present. After any fault the controller passes through startup again before the switch can close.

The confirmation window is counted in ticks from an internal prescaler. The window lasts `TICK_DIV * CONFIRM_TICKS` clock cycles, and both counters restart whenever the controller is not confirming.

Top module: `stby_aux_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the controller in its startup state; on the cycle after a reset edge `aux_en` = 0 and `skip_req` = 0.
- R2: In startup, `aux_en` stays 0 while `startup_ok` = 0. With `startup_ok` = 1 and no fault, `aux_en` becomes 1 one cycle later.
- R3: While operating (normal, confirming or standby), `skip_req` equals the inverse of `fb_over_skip` sampled one clock earlier.
- R4: After `fb_over_skip` falls in normal operation, `aux_en` stays 1 for exactly `TICK_DIV*CONFIRM_TICKS` cycles in the confirming state, then drops to 0 (standby).
- R5: If `fb_over_skip` returns to 1 before the window expires, the controller returns to normal operation. A later light-load event needs a full new window before `aux_en` drops.
- R6: In standby, `fb_over_exit` = 1 (with no fault) sets `aux_en` = 1 on the very next cycle.
- R7: In standby, toggling `fb_over_skip` while `fb_over_exit` = 0 leaves `aux_en` at 0.
- R8: `fault_ok` = 1 or `latch_off` = 1 drives `aux_en` to 0 on the next cycle from any state, and `skip_req` is 1 while the fault state holds.
- R9: `aux_en` stays 0 as long as `fault_ok` or `latch_off` is high. Once both are low the controller re-enters startup and needs `startup_ok` again before `aux_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_over_skip | input | 1 | Feedback above the light-load (skip) level |
| fb_over_exit | input | 1 | Feedback above the standby exit level |
| fault_ok | input | 1 | Overload fault confirmed |
| latch_off | input | 1 | External latch-off active |
| startup_ok | input | 1 | Startup confirmed good |
| aux_en | output | 1 | Auxiliary bias switch closed when 1 |
| skip_req | output | 1 | Request to blank drive pulses |

## Verification
The hardest situation to reach is the last cycle of the confirmation window. There the prescaler and the tick counter are both at their final value, and a single cycle decides between staying in normal operation and entering standby. The stimulus drives the light-load flag low at a known edge, counts clock edges to the cycle before expiry and after it, and samples `aux_en` on both sides. A second run pulls the flag high for one cycle part-way through the window, then checks that a full fresh window is needed.

// File: rtl/stby_pkg.sv
package stby_pkg;
   typedef enum logic [2:0] {
      ST_BOOT    = 3'd0,
      ST_RUN     = 3'd1,
      ST_CONFIRM = 3'd2,
      ST_STBY    = 3'd3,
      ST_FAULT   = 3'd4
   } stby_state_t;
endpackage

// File: rtl/stby_tick_gen.sv
module stby_tick_gen #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   output logic tick
);
   initial begin
      if (DIV < 1) $error("stby_tick_gen: DIV must be at least 1");
   end

   generate
      if (DIV == 1) begin : g_direct
         assign tick = ~clr;
      end else begin : g_count
         localparam int unsigned W = $clog2(DIV);
         logic [W-1:0] cnt_q;
         logic         wrap;
         assign wrap = (cnt_q == W'(DIV - 1));
         assign tick = ~clr & wrap;
         always_ff @(posedge clk) begin
            if (rst || clr || wrap) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/stby_confirm_timer.sv
module stby_confirm_timer #(
   parameter int unsigned TICKS = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic tick,
   output logic expired
);
   localparam int unsigned W = (TICKS > 1) ? $clog2(TICKS) : 1;

   initial begin
      if (TICKS < 1) $error("stby_confirm_timer: TICKS must be at least 1");
   end

   logic [W-1:0] cnt_q;
   logic         last;

   assign last    = (cnt_q == W'(TICKS - 1));
   assign expired = ~clr & tick & last;

   always_ff @(posedge clk) begin
      if (rst || clr || expired) cnt_q <= '0;
      else if (tick)             cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
   import stby_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        fb_over_skip,
   input  logic        fb_over_exit,
   input  logic        fault_ok,
   input  logic        latch_off,
   input  logic        startup_ok,
   input  logic        expired,
   output stby_state_t state_q,
   output logic        skip_q
);
   stby_state_t state_d;
   logic        skip_d;
   logic        any_fault;

   assign any_fault = fault_ok | latch_off;

   always_comb begin
      state_d = state_q;
      if (any_fault) begin
         state_d = ST_FAULT;
      end else begin
         case (state_q)
            ST_BOOT:    if (startup_ok)    state_d = ST_RUN;
            ST_RUN:     if (!fb_over_skip) state_d = ST_CONFIRM;
            ST_CONFIRM: begin
               if (fb_over_skip) state_d = ST_RUN;
               else if (expired) state_d = ST_STBY;
            end
            ST_STBY:    if (fb_over_exit)  state_d = ST_RUN;
            ST_FAULT:   state_d = ST_BOOT;
            default:    state_d = ST_BOOT;
         endcase
      end
   end

   always_comb begin
      case (state_d)
         ST_FAULT: skip_d = 1'b1;
         ST_BOOT:  skip_d = 1'b0;
         default:  skip_d = ~fb_over_skip;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_BOOT;
         skip_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         skip_q  <= skip_d;
      end
   end
endmodule

// File: rtl/stby_aux_ctrl.sv
module stby_aux_ctrl
   import stby_pkg::*;
#(
   parameter int unsigned TICK_DIV      = 125000,
   parameter int unsigned CONFIRM_TICKS = 125
) (
   input  logic clk,
   input  logic rst,
   input  logic fb_over_skip,
   input  logic fb_over_exit,
   input  logic fault_ok,
   input  logic latch_off,
   input  logic startup_ok,
   output logic aux_en,
   output logic skip_req
);
   stby_state_t state_q;
   logic        timer_clr;
   logic        tick;
   logic        expired;

   assign timer_clr = (state_q != ST_CONFIRM);

   stby_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk  (clk),
      .rst  (rst),
      .clr  (timer_clr),
      .tick (tick)
   );

   stby_confirm_timer #(.TICKS(CONFIRM_TICKS)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .clr     (timer_clr),
      .tick    (tick),
      .expired (expired)
   );

   stby_fsm u_fsm (
      .clk          (clk),
      .rst          (rst),
      .fb_over_skip (fb_over_skip),
      .fb_over_exit (fb_over_exit),
      .fault_ok     (fault_ok),
      .latch_off    (latch_off),
      .startup_ok   (startup_ok),
      .expired      (expired),
      .state_q      (state_q),
      .skip_q       (skip_req)
   );

   assign aux_en = (state_q == ST_RUN) || (state_q == ST_CONFIRM);
endmodule

// File: rtl/stby_aux_ctrl_chk.sv
module stby_aux_ctrl_chk
   import stby_pkg::*;
(
   input logic        clk,
   input logic        rst,
   input logic        fb_over_skip,
   input logic        fb_over_exit,
   input logic        fault_ok,
   input logic        latch_off,
   input logic        startup_ok,
   input logic        aux_en,
   input logic        skip_req,
   input stby_state_t state_q,
   input logic        expired
);
   // R1
   reset_state_chk: assert property (@(posedge clk) rst |=> (!aux_en && !skip_req));

   // R2
   boot_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_BOOT && !startup_ok) |=> !aux_en);

   // R4
   open_needs_expiry_chk: assert property (@(posedge clk) disable iff (rst)
      (aux_en && !fault_ok && !latch_off && !expired) |=> aux_en);

   // R6
   fast_exit_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_STBY && fb_over_exit && !fault_ok && !latch_off) |=> aux_en);

   // R7
   ripple_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_STBY && !fb_over_exit) |=> !aux_en);

   // R8
   fault_open_chk: assert property (@(posedge clk) disable iff (rst)
      (fault_ok || latch_off) |=> (!aux_en && skip_req));

   // R9
   fault_to_boot_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_FAULT) |=> !aux_en);
endmodule

bind stby_aux_ctrl stby_aux_ctrl_chk u_chk (
   .clk          (clk),
   .rst          (rst),
   .fb_over_skip (fb_over_skip),
   .fb_over_exit (fb_over_exit),
   .fault_ok     (fault_ok),
   .latch_off    (latch_off),
   .startup_ok   (startup_ok),
   .aux_en       (aux_en),
   .skip_req     (skip_req),
   .state_q      (state_q),
   .expired      (expired)
);

// File: tb/stby_aux_ctrl_tb.sv
module stby_aux_ctrl_tb_top;
   localparam int unsigned DIV = 4;
   localparam int unsigned TCK = 5;
   localparam int unsigned WIN = DIV * TCK;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic fb_over_skip = 1'b1;
   logic fb_over_exit = 1'b1;
   logic fault_ok = 1'b0;
   logic latch_off = 1'b0;
   logic startup_ok = 1'b0;
   logic aux_en;
   logic skip_req;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   stby_aux_ctrl #(.TICK_DIV(DIV), .CONFIRM_TICKS(TCK)) dut_i (
      .clk          (clk),
      .rst          (rst),
      .fb_over_skip (fb_over_skip),
      .fb_over_exit (fb_over_exit),
      .fault_ok     (fault_ok),
      .latch_off    (latch_off),
      .startup_ok   (startup_ok),
      .aux_en       (aux_en),
      .skip_req     (skip_req)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   // advance n rising edges and settle at the following falling edge
   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic go_run();
      fb_over_skip = 1'b1; fb_over_exit = 1'b1;
      fault_ok = 1'b0; latch_off = 1'b0; startup_ok = 1'b1;
      step(2);
   endtask

   task automatic go_standby();
      go_run();
      fb_over_skip = 1'b0; fb_over_exit = 1'b0;
      step(WIN + 1);
   endtask

   task automatic t_reset();
      rst = 1'b1; startup_ok = 1'b1;
      step(1);
      chk("R1", "aux_en after reset", aux_en, 1'b0);
      chk("R1", "skip_req after reset", skip_req, 1'b0);
      rst = 1'b0; startup_ok = 1'b0;
   endtask

   task automatic t_startup();
      startup_ok = 1'b0;
      step(5);
      chk("R2", "aux_en while startup pending", aux_en, 1'b0);
      startup_ok = 1'b1;
      step(1);
      chk("R2", "aux_en one cycle after startup_ok", aux_en, 1'b1);
   endtask

   task automatic t_skip_follow();
      go_run();
      fb_over_skip = 1'b0;
      step(1);
      chk("R3", "skip_req after light load", skip_req, 1'b1);
      fb_over_skip = 1'b1;
      step(1);
      chk("R3", "skip_req after load returns", skip_req, 1'b0);
   endtask

   task automatic t_entry();
      go_run();
      fb_over_skip = 1'b0; fb_over_exit = 1'b0;
      step(WIN);
      chk("R4", "aux_en on last confirm cycle", aux_en, 1'b1);
      step(1);
      chk("R4", "aux_en after window", aux_en, 1'b0);
   endtask

   task automatic t_restart();
      go_run();
      fb_over_skip = 1'b0; fb_over_exit = 1'b0;
      step(WIN - 3);
      fb_over_skip = 1'b1;
      step(1);
      chk("R5", "aux_en after early recovery", aux_en, 1'b1);
      fb_over_skip = 1'b0;
      step(WIN);
      chk("R5", "aux_en needs full fresh window", aux_en, 1'b1);
      step(1);
      chk("R5", "aux_en after fresh window", aux_en, 1'b0);
   endtask

   task automatic t_exit();
      go_standby();
      chk("R6", "in standby before exit", aux_en, 1'b0);
      fb_over_skip = 1'b1; fb_over_exit = 1'b1;
      step(1);
      chk("R6", "aux_en immediately after exit", aux_en, 1'b1);
   endtask

   task automatic t_ripple();
      go_standby();
      for (int i = 0; i < 6; i++) begin
         fb_over_skip = i[0];
         step(1);
         chk("R7", "aux_en during ripple", aux_en, 1'b0);
         chk("R3", "skip_req follows ripple", skip_req, ~i[0]);
      end
   endtask

   task automatic t_fault();
      go_run();
      fault_ok = 1'b1;
      step(1);
      chk("R8", "aux_en after fault", aux_en, 1'b0);
      chk("R8", "skip_req in fault", skip_req, 1'b1);
      step(3);
      chk("R9", "aux_en held during fault", aux_en, 1'b0);
      fault_ok = 1'b0; startup_ok = 1'b0;
      step(3);
      chk("R9", "aux_en waits for startup after fault", aux_en, 1'b0);
      startup_ok = 1'b1;
      step(1);
      chk("R9", "aux_en after new startup", aux_en, 1'b1);
   endtask

   task automatic t_latch();
      go_standby();
      latch_off = 1'b1;
      step(1);
      chk("R8", "skip_req on latch-off", skip_req, 1'b1);
      fb_over_exit = 1'b1; fb_over_skip = 1'b1;
      step(2);
      chk("R9", "exit ignored while latched", aux_en, 1'b0);
      latch_off = 1'b0;
      step(2);
      chk("R9", "aux_en back after latch release", aux_en, 1'b1);
   endtask

   initial begin : watchdog
      #(8 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      @(negedge clk);
      t_reset();
      t_startup();
      t_skip_follow();
      t_entry();
      t_restart();
      t_exit();
      t_ripple();
      t_fault();
      t_latch();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule